// File: doc/BRIEF.md
# Program Sequencer with Interrupt Bank

This block produces the program memory address for a small controller that has no branch target field in its instructions. An up-counter moves through program memory one word per instruction cycle, and it wraps to zero when it overflows, so a program with no branches runs again and again. A single bank flop sits on top of the counter and selects one of two halves of program memory. The lower half holds the main program and the upper half holds the interrupt routine.

The processor drives three strobes. The restart strobe sends the counter back to the first word of the current bank. The exit strobe also sends the counter to zero, and it clears the bank flop so that the main program runs again. An interrupt request sets the bank flop and starts the interrupt routine from its first word. The address is the bank bit followed by the counter value. It leaves the block straight from registers, with no logic after them.

Top module: `prog_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the counter and the bank flop both clear, so `pc_addr_o` reads 0 in the cycle after that edge.
- R2: `pc_addr_o[8]` is the bank bit (0 for main, 1 for interrupt), and `pc_addr_o[7:0]` is the counter. When `adv_i` is high and no strobe is high, the counter goes up by one at the edge and the bank bit does not change.
- R3: If the counter is 255 and it advances, it goes to 0 and the bank bit stays the same, in either bank.
- R4: With `adv_i`, `jump_i`, `ret_i` and `irq_i` all low, `pc_addr_o` does not change.
- R5: `irq_i` high in the main bank sets the bank bit and clears the counter, so the next address is 0x100.
- R6: `irq_i` high while already in the interrupt bank clears the counter again, so the next address is 0x100.
- R7: `jump_i` clears the counter and leaves the bank bit as it is, in either bank. It wins over `adv_i`.
- R8: `ret_i` clears the counter and the bank bit, so the next address is 0x000. It wins over `jump_i` and `adv_i`.
- R9: If `irq_i` is high in the same cycle as `ret_i` or `jump_i`, the interrupt wins and the next address is 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Instruction cycle strobe, moves the counter forward |
| jump_i | input | 1 | Restart strobe: counter to zero, bank unchanged |
| ret_i | input | 1 | Exit strobe: counter to zero, back to the main bank |
| irq_i | input | 1 | Interrupt request: interrupt bank, counter to zero |
| pc_addr_o | output | 9 | Program memory address, with the bank bit as MSB |

## Verification
The bench steps the counter across 255 in both banks. A design that carries the overflow into the bank bit would jump from the interrupt routine into the main program at the wrap, or from the main program into the interrupt routine.

It also drives strobes at the same time as each other and together with `adv_i`, to check the priority order. If the interrupt does not win over the exit strobe, the address lands on 0x000 when it should be 0x100. If the restart strobe clears the bank bit, the interrupt routine is left without an exit strobe.

The bench sends a second interrupt while the interrupt routine is already running, and it applies the restart strobe in the interrupt bank. In both cases the expected address is 0x100.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_JUMP,
        ACT_RET,
        ACT_IRQ
    } seq_act_e;

    typedef struct packed {
        logic inc_cnt;
        logic clr_cnt;
        logic set_bank;
        logic clr_bank;
    } seq_ctl_t;

    // priority: interrupt, exit, restart, advance
    function automatic seq_act_e pick_act(input logic adv, input logic jmp,
                                          input logic ret, input logic irq);
        if (irq)      return ACT_IRQ;
        else if (ret) return ACT_RET;
        else if (jmp) return ACT_JUMP;
        else if (adv) return ACT_STEP;
        else          return ACT_HOLD;
    endfunction

    function automatic seq_ctl_t act_ctl(input seq_act_e act);
        seq_ctl_t c;
        c = '0;
        case (act)
            ACT_STEP: c.inc_cnt = 1'b1;
            ACT_JUMP: c.clr_cnt = 1'b1;
            ACT_RET: begin
                c.clr_cnt  = 1'b1;
                c.clr_bank = 1'b1;
            end
            ACT_IRQ: begin
                c.clr_cnt  = 1'b1;
                c.set_bank = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pseq_arbiter.sv
module pseq_arbiter
    import pseq_pkg::*;
(
    input  logic     adv,
    input  logic     jmp,
    input  logic     ret,
    input  logic     irq,
    output seq_ctl_t ctl
);
    seq_act_e act;

    always_comb begin
        act = pick_act(adv, jmp, ret, irq);
        ctl = act_ctl(act);
    end
endmodule

// File: rtl/pseq_counter.sv
module pseq_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pseq_bank.sv
module pseq_bank (
    input  logic clk,
    input  logic rst,
    input  logic set_b,
    input  logic clr_b,
    output logic bank
);
    logic bank_q;

    always_ff @(posedge clk) begin
        if (rst)        bank_q <= 1'b0;
        else if (set_b) bank_q <= 1'b1;
        else if (clr_b) bank_q <= 1'b0;
    end

    assign bank = bank_q;

    // R5
    bank_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_b |=> bank_q);

    // R8
    bank_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_b && !set_b) |=> !bank_q);

    // R2
    bank_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_b && !clr_b) |=> $stable(bank_q));
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
    parameter int unsigned CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_i,
    input  logic               jump_i,
    input  logic               ret_i,
    input  logic               irq_i,
    output logic [CNT_W:0]     pc_addr_o
);
    import pseq_pkg::*;

    localparam int unsigned ADDR_W = CNT_W + 1;

    seq_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;
    logic             bank;

    pseq_arbiter u_arb (
        .adv (adv_i),
        .jmp (jump_i),
        .ret (ret_i),
        .irq (irq_i),
        .ctl (ctl)
    );

    pseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (ctl.inc_cnt),
        .clr (ctl.clr_cnt),
        .cnt (cnt)
    );

    pseq_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_b (ctl.set_bank),
        .clr_b (ctl.clr_bank),
        .bank  (bank)
    );

    assign pc_addr_o = {bank, cnt};

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !jump_i && !ret_i && !irq_i) |=> $stable(pc_addr_o));

    // R9
    irq_prio_chk: assert property (@(posedge clk) disable iff (rst)
        irq_i |=> (pc_addr_o == ADDR_W'(1) << CNT_W));

    // R7
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        (jump_i && !ret_i && !irq_i) |=>
            (pc_addr_o[CNT_W-1:0] == '0 && pc_addr_o[CNT_W] == $past(pc_addr_o[CNT_W])));

    // R8
    ret_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !irq_i) |=> (pc_addr_o == '0));
endmodule

// File: tb/tb_prog_seq.sv
`timescale 1ns/100ps
module tb_prog_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0, jmp = 1'b0, ret = 1'b0, irq = 1'b0;
    logic [8:0] addr;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    prog_seq dut (
        .clk (clk), .rst (rst), .adv_i (adv), .jump_i (jmp),
        .ret_i (ret), .irq_i (irq), .pc_addr_o (addr)
    );

    task automatic chk(input string req, input logic [8:0] exp);
        checks++;
        if (addr !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", req, addr, exp);
        end
    endtask

    // drive one cycle at a falling edge, result visible at the next falling edge
    task automatic cyc(input logic a, input logic j, input logic r, input logic i);
        adv = a; jmp = j; ret = r; irq = i;
        @(negedge clk);
        adv = 0; jmp = 0; ret = 0; irq = 0;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) cyc(1, 0, 0, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 reset", 9'h000);
        rst = 1'b0;
    endtask

    task automatic t_step_hold;
        steps(3);
        chk("R2 step", 9'h003);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        chk("R4 hold", 9'h003);
    endtask

    task automatic t_wrap_main;
        steps(252);
        chk("R3 pre-wrap main", 9'h0FF);
        steps(1);
        chk("R3 wrap main", 9'h000);
    endtask

    task automatic t_jump_main;
        steps(5);
        cyc(1, 1, 0, 0);
        chk("R7 jump main", 9'h000);
    endtask

    task automatic t_irq;
        steps(7);
        cyc(0, 0, 0, 1);
        chk("R5 irq from main", 9'h100);
        steps(3);
        chk("R2 step in isr", 9'h103);
        cyc(0, 0, 0, 1);
        chk("R6 irq in isr", 9'h100);
    endtask

    task automatic t_isr_ops;
        steps(2);
        cyc(1, 1, 0, 0);
        chk("R7 jump isr", 9'h100);
        steps(255);
        chk("R3 pre-wrap isr", 9'h1FF);
        steps(1);
        chk("R3 wrap isr", 9'h100);
        steps(4);
        cyc(1, 1, 1, 0);
        chk("R8 ret", 9'h000);
    endtask

    task automatic t_prio;
        steps(2);
        cyc(0, 0, 1, 1);
        chk("R9 irq over ret", 9'h100);
        steps(2);
        cyc(0, 1, 1, 1);
        chk("R9 irq over jump+ret", 9'h100);
        steps(1);
        cyc(0, 1, 1, 0);
        chk("R8 ret over jump", 9'h000);
        rst = 1'b1;
        cyc(1, 0, 0, 1);
        rst = 1'b0;
        chk("R1 reset over irq", 9'h000);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_step_hold();
        t_wrap_main();
        t_jump_main();
        t_irq();
        t_isr_ops();
        t_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule